// File: doc/BRIEF.md
# Edge/Level Interrupt Request Servicing Unit

This unit sits between a bank of interrupt input lines and the logic that hands interrupts to processors. It keeps two state bits for every input pin: a request bit and a bit meaning "delivered, waiting for acknowledgement". It decides, one pin per cycle, which pin is sent out next. Each pin has configuration inputs for line polarity, trigger type (edge or level), mask, vector and delivery mode. Register access and destination decoding are left to neighbouring blocks.

An edge-triggered pin is delivered once for each rising edge of its effective level. A level-triggered pin is delivered while its effective level is high. Once a delivery of a level-triggered pin is accepted, that pin stays held until an end-of-interrupt message with the pin's vector arrives. If the line is still high at that point, the pin is delivered again. A delivery request leaves the unit on registered outputs. The accept input is sampled in the same cycle as the request.

Top module: `irq_service_unit`

## Requirements
- R1: A pin's effective level is its line input XOR its polarity bit. For a level-triggered pin, the request bit equals the effective level sampled at the previous clock edge.
- R2: When the effective level is 0, the pin's request bit is 0 after the next clock edge, and the pin is not delivered.
- R3: An unmasked edge-triggered pin gives exactly one delivery per 0-to-1 transition of its effective level, however long the level stays high. The request is visible on the outputs after the second clock edge that follows the line change.
- R4: A masked pin is never delivered. A masked edge-triggered pin has its request bit cleared when its turn to be serviced comes.
- R5: A delivery carries the pin index, that pin's vector and delivery mode, and a trigger flag: 1 for a level-triggered pin, 0 for an edge-triggered pin.
- R6: When a level-triggered pin's delivery is accepted (accept high while the request is valid), the pin's remote-pending bit is set. While that bit is set, the pin is not delivered again.
- R7: If a level-triggered pin's delivery is not accepted, its remote-pending bit stays 0 and the pin is delivered again while its line stays high.
- R8: A level-type end-of-interrupt (eoi_valid=1, eoi_level=1) clears the remote-pending bit of every pin whose vector equals eoi_vector. Each such pin that is unmasked and still has its request bit set is then delivered again. An end-of-interrupt with eoi_level=0, or one whose vector matches no pin, changes nothing.
- R9: When several pins need service at the same time, they are delivered in consecutive cycles, lowest pin index first.
- R10: Reset (synchronous, active high) clears all request and remote-pending bits and the request-valid output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_lvl | input | NUM_PINS | Raw interrupt line levels |
| cfg_polarity | input | NUM_PINS | Per-pin polarity; 1 inverts the line |
| cfg_level_trig | input | NUM_PINS | Per-pin trigger type; 1 = level, 0 = edge |
| cfg_mask | input | NUM_PINS | Per-pin mask; 1 = masked |
| cfg_vector | input | NUM_PINS*VEC_W | Per-pin vector; pin p at bits [p*VEC_W +: VEC_W] |
| cfg_mode | input | NUM_PINS*MODE_W | Per-pin delivery mode; pin p at bits [p*MODE_W +: MODE_W] |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_level | input | 1 | End-of-interrupt is of level type |
| eoi_vector | input | VEC_W | Vector carried by the end-of-interrupt |
| dlv_accept | input | 1 | Delivery accepted, sampled while dlv_valid is high |
| dlv_valid | output | 1 | Delivery request valid |
| dlv_pin | output | $clog2(NUM_PINS) | Index of the delivered pin |
| dlv_vector | output | VEC_W | Vector of the delivered pin |
| dlv_mode | output | MODE_W | Delivery mode of the delivered pin |
| dlv_level | output | 1 | Trigger flag of the delivered pin (1 = level) |
| pend_o | output | NUM_PINS | Per-pin request bits |
| remote_o | output | NUM_PINS | Per-pin remote-pending bits |

## Verification
The hardest situation to create is redelivery after an end-of-interrupt. A level-triggered pin has to be delivered and accepted first, then kept asserted, and only then hit by an end-of-interrupt with its vector. The stimulus holds the line high across the whole sequence. It first sends end-of-interrupts that must be ignored (wrong vector, edge type), then the matching one, and counts the extra deliveries. Two pins then share one vector, so a single message must release both of them. A rejected-delivery run, with accept held low, exercises the retry path and checks that retries come every other cycle.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;
endpackage

// File: rtl/irq_pin_track.sv
module irq_pin_track
  import irq_svc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  input  logic pol_i,
  input  logic lvl_i,
  input  logic mask_i,
  input  logic grant_i,
  input  logic inflight_i,
  input  logic set_remote_i,
  input  logic eoi_hit_i,
  output logic pend_o,
  output logic remote_o,
  output logic elig_o
);
  trig_e trig;
  logic  eff, eff_q, rise;

  assign trig = trig_e'(lvl_i);
  assign eff  = line_i ^ pol_i;
  assign rise = eff & ~eff_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_q    <= 1'b0;
      pend_o   <= 1'b0;
      remote_o <= 1'b0;
    end else begin
      eff_q <= eff;
      if (trig == TRIG_LEVEL) pend_o <= eff;
      else                    pend_o <= eff & (rise | (pend_o & ~grant_i));
      if (set_remote_i)       remote_o <= 1'b1;
      else if (eoi_hit_i)     remote_o <= 1'b0;
    end
  end

  always_comb begin
    if (trig == TRIG_LEVEL) elig_o = pend_o & ~remote_o & ~mask_i & ~inflight_i;
    else                    elig_o = pend_o;
  end
endmodule

// File: rtl/irq_low_first.sv
module irq_low_first #(
  parameter int NUM_REQ = 8,
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] gnt,
  output logic [IDX_W-1:0]   idx,
  output logic               any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = NUM_REQ - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IDX_W'(i);
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_eoi_match.sv
module irq_eoi_match #(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8
) (
  input  logic                      eoi_valid,
  input  logic                      eoi_level,
  input  logic [VEC_W-1:0]          eoi_vector,
  input  logic [NUM_PINS*VEC_W-1:0] cfg_vector,
  output logic [NUM_PINS-1:0]       hit
);
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_cmp
    assign hit[g] = eoi_valid & eoi_level & (cfg_vector[g*VEC_W +: VEC_W] == eoi_vector);
  end
endmodule

// File: rtl/irq_service_unit.sv
module irq_service_unit #(
  parameter int NUM_PINS = 8,
  parameter int VEC_W    = 8,
  parameter int MODE_W   = 3,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_PINS-1:0]        line_lvl,
  input  logic [NUM_PINS-1:0]        cfg_polarity,
  input  logic [NUM_PINS-1:0]        cfg_level_trig,
  input  logic [NUM_PINS-1:0]        cfg_mask,
  input  logic [NUM_PINS*VEC_W-1:0]  cfg_vector,
  input  logic [NUM_PINS*MODE_W-1:0] cfg_mode,
  input  logic                       eoi_valid,
  input  logic                       eoi_level,
  input  logic [VEC_W-1:0]           eoi_vector,
  input  logic                       dlv_accept,
  output logic                       dlv_valid,
  output logic [IDX_W-1:0]           dlv_pin,
  output logic [VEC_W-1:0]           dlv_vector,
  output logic [MODE_W-1:0]          dlv_mode,
  output logic                       dlv_level,
  output logic [NUM_PINS-1:0]        pend_o,
  output logic [NUM_PINS-1:0]        remote_o
);
  logic [NUM_PINS-1:0] elig, gnt, eoi_hit;
  logic [IDX_W-1:0]    sel;
  logic                any_elig;

  irq_eoi_match #(.NUM_PINS(NUM_PINS), .VEC_W(VEC_W)) u_eoi (
    .eoi_valid  (eoi_valid),
    .eoi_level  (eoi_level),
    .eoi_vector (eoi_vector),
    .cfg_vector (cfg_vector),
    .hit        (eoi_hit)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic inflight, set_rem;
    assign inflight = dlv_valid && (dlv_pin == IDX_W'(g));
    assign set_rem  = inflight & dlv_accept & dlv_level;
    irq_pin_track u_pin (
      .clk          (clk),
      .rst          (rst),
      .line_i       (line_lvl[g]),
      .pol_i        (cfg_polarity[g]),
      .lvl_i        (cfg_level_trig[g]),
      .mask_i       (cfg_mask[g]),
      .grant_i      (gnt[g]),
      .inflight_i   (inflight),
      .set_remote_i (set_rem),
      .eoi_hit_i    (eoi_hit[g]),
      .pend_o       (pend_o[g]),
      .remote_o     (remote_o[g]),
      .elig_o       (elig[g])
    );
  end

  irq_low_first #(.NUM_REQ(NUM_PINS)) u_pick (
    .req (elig),
    .gnt (gnt),
    .idx (sel),
    .any (any_elig)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_valid  <= 1'b0;
      dlv_pin    <= '0;
      dlv_vector <= '0;
      dlv_mode   <= '0;
      dlv_level  <= 1'b0;
    end else begin
      dlv_valid <= any_elig & ~cfg_mask[sel];
      if (any_elig) begin
        dlv_pin    <= sel;
        dlv_vector <= cfg_vector[sel*VEC_W +: VEC_W];
        dlv_mode   <= cfg_mode[sel*MODE_W +: MODE_W];
        dlv_level  <= cfg_level_trig[sel];
      end
    end
  end
endmodule

// File: rtl/irq_service_checker.sv
module irq_service_checker #(
  parameter int NUM_PINS = 8,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] line_lvl,
  input logic [NUM_PINS-1:0] cfg_polarity,
  input logic [NUM_PINS-1:0] cfg_mask,
  input logic                eoi_valid,
  input logic                eoi_level,
  input logic                dlv_accept,
  input logic                dlv_valid,
  input logic [IDX_W-1:0]    dlv_pin,
  input logic                dlv_level,
  input logic [NUM_PINS-1:0] pend_o,
  input logic [NUM_PINS-1:0] remote_o
);
  logic [NUM_PINS-1:0] mask_q, eff_q, rem_q, pend_q;

  always_ff @(posedge clk) begin
    mask_q <= cfg_mask;
    eff_q  <= line_lvl ^ cfg_polarity;
    rem_q  <= remote_o;
    pend_q <= pend_o;
  end

  assert_masked_silent_R4: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> !mask_q[dlv_pin]);

  assert_low_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (pend_o & ~eff_q) == '0);

  assert_remote_needs_accept_R6: assert property (@(posedge clk) disable iff (rst)
    ((remote_o & ~rem_q) != '0) |-> $past(dlv_valid && dlv_accept && dlv_level));

  assert_remote_held_R8: assert property (@(posedge clk) disable iff (rst)
    ((rem_q & ~remote_o) != '0) |-> $past(eoi_valid && eoi_level));

  assert_no_redeliver_R6: assert property (@(posedge clk) disable iff (rst)
    (dlv_valid && dlv_level) |-> !rem_q[dlv_pin]);

  assert_pending_first_R3: assert property (@(posedge clk) disable iff (rst)
    dlv_valid |-> pend_q[dlv_pin]);

  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!dlv_valid && remote_o == '0 && pend_o == '0));
endmodule

bind irq_service_unit irq_service_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .line_lvl     (line_lvl),
  .cfg_polarity (cfg_polarity),
  .cfg_mask     (cfg_mask),
  .eoi_valid    (eoi_valid),
  .eoi_level    (eoi_level),
  .dlv_accept   (dlv_accept),
  .dlv_valid    (dlv_valid),
  .dlv_pin      (dlv_pin),
  .dlv_level    (dlv_level),
  .pend_o       (pend_o),
  .remote_o     (remote_o)
);

// File: tb/tb_irq_service_unit.sv
module tb_irq_service_unit;
  localparam int N  = 4;
  localparam int VW = 4;
  localparam int MW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [N-1:0]    line, pol, lvl, msk;
  logic [N*VW-1:0] vec;
  logic [N*MW-1:0] mode;
  logic            eoi_valid, eoi_level, acc;
  logic [VW-1:0]   eoi_vector;
  logic            dlv_valid, dlv_level;
  logic [IW-1:0]   dlv_pin;
  logic [VW-1:0]   dlv_vector;
  logic [MW-1:0]   dlv_mode;
  logic [N-1:0]    pend, remote;

  irq_service_unit #(.NUM_PINS(N), .VEC_W(VW), .MODE_W(MW)) dut (
    .clk(clk), .rst(rst), .line_lvl(line), .cfg_polarity(pol),
    .cfg_level_trig(lvl), .cfg_mask(msk), .cfg_vector(vec), .cfg_mode(mode),
    .eoi_valid(eoi_valid), .eoi_level(eoi_level), .eoi_vector(eoi_vector),
    .dlv_accept(acc), .dlv_valid(dlv_valid), .dlv_pin(dlv_pin),
    .dlv_vector(dlv_vector), .dlv_mode(dlv_mode), .dlv_level(dlv_level),
    .pend_o(pend), .remote_o(remote)
  );

  int n_chk = 0;
  int n_fail = 0;
  int dcnt [N];
  int order [32];
  int n_ord;

  always @(posedge clk) begin
    #2;
    if (!rst && dlv_valid) begin
      dcnt[dlv_pin] = dcnt[dlv_pin] + 1;
      if (n_ord < 32) order[n_ord] = int'(dlv_pin);
      n_ord = n_ord + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    for (int i = 0; i < N; i++) dcnt[i] = 0;
    n_ord = 0;
  endtask

  task automatic eoi(input int v, input logic lv);
    eoi_vector = VW'(v);
    eoi_level  = lv;
    eoi_valid  = 1'b1;
    tick(1);
    eoi_valid  = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    line = '0; pol = '0; lvl = '0; msk = '1;
    for (int p = 0; p < N; p++) begin
      vec[p*VW +: VW]  = VW'(p + 5);
      mode[p*MW +: MW] = MW'(p);
    end
    eoi_valid = 1'b0; eoi_level = 1'b0; eoi_vector = '0; acc = 1'b1;
    clr();
    tick(3);
    chk("R10 valid in reset", int'(dlv_valid), 0);
    chk("R10 pend in reset", int'(pend), 0);
    chk("R10 remote in reset", int'(remote), 0);
    rst = 1'b0;
    tick(2);

    // R1 / R2: polarity sweep on masked level pins
    for (int p = 0; p < N; p++) begin
      lvl[p] = 1'b1;
      for (int pl = 0; pl < 2; pl++) begin
        for (int l = 0; l < 2; l++) begin
          pol[p] = pl[0]; line[p] = l[0];
          tick(2);
          chk("R1 pend follows line xor polarity", int'(pend[p]), l ^ pl);
        end
      end
      line[p] = 1'b0; pol[p] = 1'b0;
      tick(2);
      chk("R2 low level clears pend", int'(pend[p]), 0);
      lvl[p] = 1'b0;
    end
    chk("R4 masked sweep gives no delivery", n_ord, 0);

    // R3 / R5: edge pin timing and fields
    clr();
    msk[1] = 1'b0;
    tick(1);
    line[1] = 1'b1;
    tick(1);
    chk("R3 not yet valid", int'(dlv_valid), 0);
    chk("R3 pend set", int'(pend[1]), 1);
    tick(1);
    chk("R3 valid after two edges", int'(dlv_valid), 1);
    chk("R5 pin", int'(dlv_pin), 1);
    chk("R5 vector", int'(dlv_vector), 6);
    chk("R5 mode", int'(dlv_mode), 1);
    chk("R5 edge flag", int'(dlv_level), 0);
    tick(10);
    chk("R3 single delivery while held", dcnt[1], 1);
    line[1] = 1'b0; tick(2); line[1] = 1'b1; tick(4);
    chk("R3 second edge", dcnt[1], 2);
    line[1] = 1'b0; tick(2);
    pol[1] = 1'b1; tick(4);
    chk("R1 polarity flip makes edge", dcnt[1], 3);
    pol[1] = 1'b0; msk[1] = 1'b1; tick(2);

    // R4: masked edge pin
    clr();
    line[2] = 1'b1;
    tick(1);
    chk("R4 masked edge pend set", int'(pend[2]), 1);
    tick(1);
    chk("R4 masked edge pend cleared by service", int'(pend[2]), 0);
    tick(5);
    chk("R4 masked edge not delivered", dcnt[2], 0);
    line[2] = 1'b0; tick(2);

    // R6: level pin accepted
    clr();
    lvl[0] = 1'b1; msk[0] = 1'b0; line[0] = 1'b1;
    tick(10);
    chk("R6 one delivery", dcnt[0], 1);
    chk("R6 remote set", int'(remote[0]), 1);
    chk("R5 level flag", int'(dlv_level), 1);

    // R8: ignored end-of-interrupts, then matching one
    eoi(6, 1'b1); tick(5);
    chk("R8 wrong vector ignored", int'(remote[0]), 1);
    eoi(5, 1'b0); tick(5);
    chk("R8 edge-type eoi ignored", int'(remote[0]), 1);
    chk("R8 no delivery after ignored eoi", dcnt[0], 1);
    eoi(5, 1'b1);
    chk("R8 remote cleared", int'(remote[0]), 0);
    tick(6);
    chk("R8 redelivered while asserted", dcnt[0], 2);
    chk("R8 remote set again", int'(remote[0]), 1);
    line[0] = 1'b0; tick(2);
    eoi(5, 1'b1); tick(6);
    chk("R8 no redelivery when line low", dcnt[0], 2);
    chk("R8 remote stays clear", int'(remote[0]), 0);
    msk[0] = 1'b1; lvl[0] = 1'b0;

    // R7: rejected level deliveries retry every other cycle
    clr();
    acc = 1'b0; lvl[3] = 1'b1; msk[3] = 1'b0;
    line[3] = 1'b1;
    tick(12);
    chk("R7 retries while rejected", dcnt[3], 6);
    chk("R7 remote stays clear", int'(remote[3]), 0);
    acc = 1'b1; tick(4);
    chk("R6 accept sets remote", int'(remote[3]), 1);
    line[3] = 1'b0; msk[3] = 1'b1; tick(2);
    eoi(8, 1'b1); tick(2);
    lvl[3] = 1'b0;

    // R9: simultaneous edges served lowest first
    clr();
    msk = '0;
    line = '1;
    tick(1);
    for (int i = 0; i < N; i++) begin
      tick(1);
      chk("R9 valid each cycle", int'(dlv_valid), 1);
      chk("R9 lowest index order", int'(dlv_pin), i);
    end
    tick(4);
    chk("R9 total deliveries", n_ord, N);
    line = '0; msk = '1; tick(2);

    // R8: one eoi releases every pin sharing the vector
    clr();
    vec[1*VW +: VW] = 4'hA; vec[2*VW +: VW] = 4'hA;
    lvl[1] = 1'b1; lvl[2] = 1'b1; msk[1] = 1'b0; msk[2] = 1'b0;
    line[1] = 1'b1; line[2] = 1'b1;
    tick(8);
    chk("R6 shared pin1 once", dcnt[1], 1);
    chk("R6 shared pin2 once", dcnt[2], 1);
    chk("R6 both remote", int'(remote), 6);
    eoi(10, 1'b1); tick(8);
    chk("R8 shared pin1 again", dcnt[1], 2);
    chk("R8 shared pin2 again", dcnt[2], 2);
    chk("R8 both remote again", int'(remote), 6);

    // R10: reset in operation
    rst = 1'b1; tick(2);
    chk("R10 pend cleared", int'(pend), 0);
    chk("R10 remote cleared", int'(remote), 0);
    chk("R10 valid cleared", int'(dlv_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule